// File: doc/BRIEF.md
# Queued shared-bus arbiter

This block decides which of up to eight processor ports owns a single time-shared common bus. A port raises its request line on any clock cycle and holds it. When the bus is free, the arbiter hands it to the oldest waiting port. Ports that raised their requests in the same cycle are ranked by ascending index. The owner keeps the bus for a fixed number of data cycles. One more clock then follows in which the arbiter clears its state, and the next waiting port takes the bus on the clock after that. No idle gap is added.

Every port that is requesting but not granted sees its stall line high, so its access stretches by whole clock cycles; its clock keeps running. Because service is first come, first served, a port waits at most one tenure per other port, and low-numbered ports cannot starve high-numbered ones. A saturating counter per port totals the stalled cycles, so bus interference can be read as extra execution time. All pins are plain control and status levels: there is no data path, so there is no valid/ready handshake and no back-pressure.

Top module: `cbus_fifo_arbiter`

## Requirements
- R1: At most one bit of `bus_gnt` is high in any cycle, and only the current owner's bit.
- R2: While the bus is idle and no request is queued, a new request sampled at a clock edge gives that port `bus_gnt` right after that same edge.
- R3: An owner's `bus_gnt` bit stays high for exactly DATA_CYC (default 3) consecutive cycles.
- R4: Each tenure is followed by exactly one reset cycle, in which `bus_gnt` is all zero and `bus_busy` is high. The next queued port is granted in the cycle right after it.
- R5: Ports are granted in the order in which their requests first arrived, whatever their index.
- R6: Requests first seen at the same edge are ordered by ascending port index, with port 0 first.
- R7: With all NPORT ports requesting at once, port k is granted 1 + (DATA_CYC+1)·k cycles after the request edge, so no wait exceeds (DATA_CYC+1)·(NPORT-1) + 1 cycles.
- R8: `bus_stall[i]` is high exactly when `bus_req[i]` is high and `bus_gnt[i]` is low.
- R9: A port that still holds its request after its tenure is not queued again. It must be sampled low at an edge where it does not own the bus before a later request counts as new.
- R10: Counter i (bits i·CNT_W upward in `stall_cnt`) adds one at every edge where `bus_stall[i]` is high and stops at 2^CNT_W − 1.
- R11: A synchronous active-high `rst` empties the queue, frees the bus (`bus_gnt` = 0, `bus_busy` = 0), clears all blocked marks and clears every counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | NPORT | Request level per port, held until served |
| bus_gnt | output | NPORT | One-hot bus ownership during data cycles |
| bus_stall | output | NPORT | Wait indication per port |
| bus_busy | output | 1 | High during a tenure and its reset cycle |
| stall_cnt | output | NPORT·CNT_W | Saturating stalled-cycle count per port, port 0 in the low bits |

## Verification
Two events can fall on the same edge: the hand-off at the end of a reset cycle and the arrival of a fresh request. The hand-off must take the queue head, and the newcomer must go behind entries that are already queued. The vector table provokes this by raising a lower-numbered port while a higher-numbered port is already waiting, and then lining the reset cycle up with another arrival. It is judged by the one-hot grant sequence seen at each step. A second collision is a blocked port releasing its request while the bus passes to another port. This is judged by whether that port's later request is queued again.

// File: rtl/cbus_arb_pkg.sv
package cbus_arb_pkg;

  // Bus ownership phase of the tenure sequencer.
  typedef enum logic [1:0] {
    TN_IDLE  = 2'd0,
    TN_DATA  = 2'd1,
    TN_RESET = 2'd2
  } tenure_e;

endpackage

// File: rtl/cbus_arb_admit.sv
// Decides which requests are new this cycle; remembers served ports
// until they release their request line.
module cbus_arb_admit #(
  parameter int NPORT = 8,
  parameter int IW    = $clog2(NPORT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPORT-1:0] req,
  input  logic [NPORT-1:0] in_queue,
  input  logic [NPORT-1:0] own_mask,
  input  logic             take,
  input  logic [IW-1:0]    take_idx,
  output logic [NPORT-1:0] arrive
);

  logic [NPORT-1:0] blocked_q;

  always_comb arrive = req & ~in_queue & ~blocked_q & ~own_mask;

  for (genvar g = 0; g < NPORT; g++) begin : g_blk
    always_ff @(posedge clk) begin
      if (rst) begin
        blocked_q[g] <= 1'b0;
      end else if (take && (take_idx == IW'(g))) begin
        blocked_q[g] <= 1'b1;
      end else if (!req[g] && !own_mask[g]) begin
        blocked_q[g] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cbus_arb_queue.sv
// Arrival-ordered queue of port indices. Same-cycle arrivals are
// appended in ascending index order behind the entries already held.
module cbus_arb_queue #(
  parameter int NPORT = 8,
  parameter int IW    = $clog2(NPORT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPORT-1:0] arrive,
  input  logic             take,
  output logic [IW-1:0]    head_idx,
  output logic             head_vld,
  output logic [NPORT-1:0] in_queue
);

  localparam int CW = $clog2(NPORT + 1);

  logic [IW-1:0] slot_q [NPORT];
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] merged [NPORT];
  logic [CW-1:0] mcnt;

  // Held entries followed by this cycle's arrivals.
  always_comb begin
    for (int j = 0; j < NPORT; j++) merged[j] = slot_q[j];
    mcnt = cnt_q;
    for (int i = 0; i < NPORT; i++) begin
      if (arrive[i]) begin
        for (int j = 0; j < NPORT; j++) begin
          if (CW'(j) == mcnt) merged[j] = IW'(i);
        end
        mcnt = mcnt + CW'(1);
      end
    end
  end

  always_comb begin
    head_idx = merged[0];
    head_vld = (mcnt != '0);
  end

  always_comb begin
    in_queue = '0;
    for (int j = 0; j < NPORT; j++) begin
      if (CW'(j) < cnt_q) in_queue[slot_q[j]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      for (int j = 0; j < NPORT; j++) slot_q[j] <= '0;
    end else if (take) begin
      for (int j = 0; j < NPORT - 1; j++) slot_q[j] <= merged[j+1];
      slot_q[NPORT-1] <= merged[NPORT-1];
      cnt_q <= mcnt - CW'(1);
    end else begin
      for (int j = 0; j < NPORT; j++) slot_q[j] <= merged[j];
      cnt_q <= mcnt;
    end
  end

endmodule

// File: rtl/cbus_arb_tenure.sv
// Owner register and phase counter: DATA_CYC data cycles, then one
// reset cycle, then the bus is free for the next owner.
module cbus_arb_tenure
  import cbus_arb_pkg::*;
#(
  parameter int NPORT    = 8,
  parameter int IW       = $clog2(NPORT),
  parameter int DATA_CYC = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             head_vld,
  input  logic [IW-1:0]    head_idx,
  output logic             take,
  output logic [IW-1:0]    owner,
  output logic [NPORT-1:0] grant,
  output logic [NPORT-1:0] own_mask,
  output logic             busy
);

  localparam int PW = $clog2(DATA_CYC + 1);
  localparam logic [PW-1:0] LAST_PH = PW'(DATA_CYC - 1);

  tenure_e          st_q;
  logic [IW-1:0]    own_q;
  logic [PW-1:0]    ph_q;
  logic [NPORT-1:0] own_oh;

  always_comb take = (st_q != TN_DATA) && head_vld;

  always_comb begin
    own_oh = '0;
    own_oh[own_q] = 1'b1;
  end

  always_comb begin
    owner    = own_q;
    busy     = (st_q != TN_IDLE);
    grant    = (st_q == TN_DATA) ? own_oh : '0;
    own_mask = busy ? own_oh : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= TN_IDLE;
      own_q <= '0;
      ph_q  <= '0;
    end else if (take) begin
      st_q  <= TN_DATA;
      own_q <= head_idx;
      ph_q  <= '0;
    end else begin
      unique case (st_q)
        TN_DATA: begin
          if (ph_q == LAST_PH) st_q <= TN_RESET;
          else                 ph_q <= ph_q + PW'(1);
        end
        TN_RESET: st_q <= TN_IDLE;
        default:  st_q <= TN_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cbus_arb_stall_ctr.sv
// Saturating count of stalled cycles for one port.
module cbus_arb_stall_ctr #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst)                   cnt <= '0;
    else if (inc && cnt != '1) cnt <= cnt + CNT_W'(1);
  end

endmodule

// File: rtl/cbus_fifo_arbiter.sv
module cbus_fifo_arbiter #(
  parameter int NPORT    = 8,
  parameter int DATA_CYC = 3,
  parameter int CNT_W    = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NPORT-1:0]       bus_req,
  output logic [NPORT-1:0]       bus_gnt,
  output logic [NPORT-1:0]       bus_stall,
  output logic                   bus_busy,
  output logic [NPORT*CNT_W-1:0] stall_cnt
);

  localparam int IW = $clog2(NPORT);

  logic [NPORT-1:0] arrive;
  logic [NPORT-1:0] in_queue;
  logic [NPORT-1:0] own_mask;
  logic [IW-1:0]    head_idx;
  logic [IW-1:0]    owner;
  logic             head_vld;
  logic             take;

  cbus_arb_admit #(.NPORT(NPORT), .IW(IW)) u_admit (
    .clk      (clk),
    .rst      (rst),
    .req      (bus_req),
    .in_queue (in_queue),
    .own_mask (own_mask),
    .take     (take),
    .take_idx (head_idx),
    .arrive   (arrive)
  );

  cbus_arb_queue #(.NPORT(NPORT), .IW(IW)) u_queue (
    .clk      (clk),
    .rst      (rst),
    .arrive   (arrive),
    .take     (take),
    .head_idx (head_idx),
    .head_vld (head_vld),
    .in_queue (in_queue)
  );

  cbus_arb_tenure #(.NPORT(NPORT), .IW(IW), .DATA_CYC(DATA_CYC)) u_tenure (
    .clk      (clk),
    .rst      (rst),
    .head_vld (head_vld),
    .head_idx (head_idx),
    .take     (take),
    .owner    (owner),
    .grant    (bus_gnt),
    .own_mask (own_mask),
    .busy     (bus_busy)
  );

  always_comb bus_stall = bus_req & ~bus_gnt;

  for (genvar g = 0; g < NPORT; g++) begin : g_ctr
    cbus_arb_stall_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk (clk),
      .rst (rst),
      .inc (bus_stall[g]),
      .cnt (stall_cnt[g*CNT_W +: CNT_W])
    );
  end

endmodule

// File: rtl/cbus_fifo_arbiter_chk.sv
module cbus_fifo_arbiter_chk #(
  parameter int NPORT    = 8,
  parameter int DATA_CYC = 3,
  parameter int CNT_W    = 32
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NPORT-1:0]       bus_req,
  input logic [NPORT-1:0]       bus_gnt,
  input logic [NPORT-1:0]       bus_stall,
  input logic                   bus_busy,
  input logic [NPORT*CNT_W-1:0] stall_cnt
);

  // R1: a single owner at most
  a_r1_one_owner: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bus_gnt));

  // R3: a fresh grant is still held on the next two cycles
  a_r3_tenure_hold: assert property (@(posedge clk) disable iff (rst)
    (bus_gnt != '0 && $past(bus_gnt) == '0)
      |=> (bus_gnt == $past(bus_gnt)) ##1 (bus_gnt == $past(bus_gnt)));

  // R4: grant ends into a busy reset cycle
  a_r4_reset_cycle: assert property (@(posedge clk) disable iff (rst)
    $fell(|bus_gnt) |-> bus_busy);

  // R4: ownership never passes straight from one port to another
  a_r4_no_direct_swap: assert property (@(posedge clk) disable iff (rst)
    (bus_gnt != '0 && $past(bus_gnt) != '0) |-> bus_gnt == $past(bus_gnt));

  // R8: the owner is never told to stall
  a_r8_owner_runs: assert property (@(posedge clk) disable iff (rst)
    (bus_stall & bus_gnt) == '0);

  // R11: reset frees the bus and clears counters
  a_r11_reset_clear: assert property (@(posedge clk)
    rst |=> (bus_gnt == '0 && !bus_busy && stall_cnt == '0));

  for (genvar g = 0; g < NPORT; g++) begin : g_cnt
    // R10: counters never fall and step by at most one
    a_r10_monotonic: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) == 1'b0) |->
        (stall_cnt[g*CNT_W +: CNT_W] >= $past(stall_cnt[g*CNT_W +: CNT_W]) &&
         stall_cnt[g*CNT_W +: CNT_W] - $past(stall_cnt[g*CNT_W +: CNT_W]) <= CNT_W'(1)));
  end

endmodule

bind cbus_fifo_arbiter cbus_fifo_arbiter_chk #(
  .NPORT(NPORT), .DATA_CYC(DATA_CYC), .CNT_W(CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_req   (bus_req),
  .bus_gnt   (bus_gnt),
  .bus_stall (bus_stall),
  .bus_busy  (bus_busy),
  .stall_cnt (stall_cnt)
);

// File: tb/cbus_fifo_arbiter_bench.sv
`timescale 1ns/1ps
module cbus_fifo_arbiter_bench;

  localparam int NP = 8;
  localparam int CW = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NP-1:0]   req = '0;
  logic [NP-1:0]   gnt;
  logic [NP-1:0]   stall;
  logic            busy;
  logic [NP*CW-1:0] cnt;

  logic [1:0] req2 = '0;
  logic [1:0] gnt2;
  logic [1:0] stall2;
  logic       busy2;
  logic [5:0] cnt2;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  cbus_fifo_arbiter #(.NPORT(NP), .DATA_CYC(3), .CNT_W(CW)) u_cbus_fifo_arbiter (
    .clk(clk), .rst(rst), .bus_req(req), .bus_gnt(gnt),
    .bus_stall(stall), .bus_busy(busy), .stall_cnt(cnt)
  );

  cbus_fifo_arbiter #(.NPORT(2), .DATA_CYC(3), .CNT_W(3)) u_cbus_fifo_arbiter_sat (
    .clk(clk), .rst(rst), .bus_req(req2), .bus_gnt(gnt2),
    .bus_stall(stall2), .bus_busy(busy2), .stall_cnt(cnt2)
  );

  // {req, expected grant} per step; grant seen right after the step's edge.
  localparam logic [15:0] TBL [20] = '{
    16'h00_00, 16'h04_04, 16'h24_04, 16'h25_04, 16'h25_00,
    16'h21_20, 16'h21_20, 16'h21_20, 16'h01_00, 16'h05_01,
    16'h05_01, 16'h05_01, 16'h04_00, 16'h04_04, 16'h04_04,
    16'h04_04, 16'h04_00, 16'h04_00, 16'h00_00, 16'h04_04
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
  endtask

  initial begin
    #(8ns * 100000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R11 reset state
    check("R11 grant after reset", 32'(gnt), 32'h0);
    check("R11 busy after reset", 32'(busy), 32'h0);
    check("R11 counter 0 after reset", cnt[0 +: CW], 32'h0);

    // R2 R3 R4 R5 R9 vector walk
    for (int k = 0; k < 20; k++) begin
      req = TBL[k][15:8];
      tick();
      check($sformatf("R2 R3 R4 R5 R9 step %0d", k), 32'(gnt), 32'(TBL[k][7:0]));
    end
    req = '0;
    repeat (6) tick();

    // R8 R10 counter timing with two ports
    do_reset();
    req = 8'h03;
    tick();
    check("R6 lower index first", 32'(gnt), 32'h01);
    check("R8 stall of waiting port", 32'(stall), 32'h02);
    req = 8'h02;
    tick();
    tick();
    tick();
    check("R4 reset cycle grant", 32'(gnt), 32'h0);
    check("R4 reset cycle busy", 32'(busy), 32'h1);
    tick();
    check("R4 immediate hand-off", 32'(gnt), 32'h02);
    check("R10 port0 count", cnt[0 +: CW], 32'd1);
    check("R10 port1 count", cnt[CW +: CW], 32'd5);
    req = '0;
    repeat (4) tick();
    check("R10 port1 count holds", cnt[CW +: CW], 32'd5);

    // R6 R7 all ports at once
    do_reset();
    req = '1;
    tick();
    check("R7 port 0 slot", 32'(gnt), 32'h01);
    check("R8 all others stall", 32'(stall), 32'hFE);
    for (int k = 1; k < NP; k++) begin
      repeat (4) tick();
      check($sformatf("R6 R7 port %0d slot", k), 32'(gnt), 32'(1 << k));
    end
    repeat (4) tick();
    check("R9 held requests not requeued", 32'(gnt), 32'h0);

    // R11 reset during traffic
    rst = 1'b1;
    tick();
    check("R11 mid-run grant", 32'(gnt), 32'h0);
    check("R11 mid-run busy", 32'(busy), 32'h0);
    check("R11 mid-run count", cnt[7*CW +: CW], 32'h0);
    rst = 1'b0;
    tick();
    check("R11 blocked marks cleared", 32'(gnt), 32'h01);
    req = '0;

    // R10 saturation on a narrow counter
    do_reset();
    req2 = 2'b11;
    repeat (12) tick();
    check("R10 saturate port0", 32'(cnt2[2:0]), 32'd7);
    check("R10 saturate port1", 32'(cnt2[5:3]), 32'd7);
    repeat (3) tick();
    check("R10 saturated stays", 32'(cnt2[2:0]), 32'd7);
    req2 = '0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule